// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider

This block divides a double-length magnitude by a single-length magnitude. Each operand has its own sign bit. A request carries a 2W-bit dividend magnitude and a W-bit divisor magnitude, together with the two sign bits. The block first compares the high half of the dividend against the divisor. If the high half is not smaller, the quotient cannot fit in W bits, or the divisor is zero. In that case the block raises the overflow flag and stops without touching the operands.

Otherwise the block produces one quotient bit per clock with a shift-and-subtract loop. The partial remainder and the quotient shift left together as one double-length register. The bit shifted out of the top of the partial remainder acts as an extra ninth bit. When that bit is 1, the divisor is subtracted without any compare. When it is 0, the subtraction is kept only if it does not go negative.

The controller has four states:
- IDLE waits for start. Its transition *accept* loads the operands.
- CHECK runs the overflow test. Its transition *reject* goes to DONE, and its transition *proceed* goes to STEP.
- STEP repeats W times. Its transition *last step* goes to DONE.
- DONE pulses done for one cycle. Its transition *release* returns to IDLE.

Top module: `rdiv_top`

## Requirements
- R1: A start pulse is accepted only in IDLE. While busy is high, start is ignored, and the running operation finishes with its own operands.
- R2: When the dividend's high half (bits [2W-1:W]) is greater than or equal to the divisor, ovf is set. In that case quot_mag returns the dividend's low half unchanged and rem_mag returns its high half unchanged.
- R3: A zero divisor always sets ovf, whatever the dividend is.
- R4: Without overflow, quot_mag equals floor(dividend/divisor) and rem_mag equals dividend mod divisor.
- R5: quot_sign is the XOR of the two input signs, and rem_sign equals the dividend sign. This holds in both the normal case and the overflow case.
- R6: done is high for exactly one cycle per operation. Counting the clock edge that accepts start as edge 1, done is high after edge W+2 without overflow, and after edge 2 on overflow.
- R7: ovf is cleared by every accepted start. It otherwise holds its value, including after done.
- R8: After reset, done, busy and ovf are 0, and the magnitude outputs are 0.
- R9: The result is correct when the bit shifted out of the partial remainder is 1. This case arises when the high half of the dividend has its top bit set but is still below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (taken in IDLE only) |
| dvd_mag | input | 2W | Dividend magnitude |
| dvd_sign | input | 1 | Dividend sign, 1 = negative |
| dvs_mag | input | W | Divisor magnitude |
| dvs_sign | input | 1 | Divisor sign, 1 = negative |
| quot_mag | output | W | Quotient magnitude |
| quot_sign | output | 1 | Quotient sign |
| rem_mag | output | W | Remainder magnitude |
| rem_sign | output | 1 | Remainder sign |
| ovf | output | 1 | Divide overflow (covers a zero divisor) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High from acceptance until done |

## Verification
The bench builds the block with W = 8, which gives a 16-bit dividend. At that width, the full boundary of the overflow test can be reached with a handful of vectors. These include a high half exactly equal to the divisor, a zero divisor, and the largest dividend that still fits. The shifted-out top bit can be reached with dividends such as 0xF000 over 0xFF. W = 8 also keeps the latency short (10 cycles), so the bench can count the latency exactly and issue a start inside the busy window.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_STEP,
        ST_DONE
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_trial_sub.sv
// Trial subtraction of the divisor from a partial remainder that is
// extended by one bit on top (the bit shifted out on the left).
module rdiv_trial_sub #(
    parameter int W = 8
) (
    input  logic         top_bit,
    input  logic [W-1:0] part,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] diff,
    output logic         fits
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, part} - {1'b0, divisor};
        diff = wide[W-1:0];
        // With the extra top bit set, the true value already exceeds the divisor.
        fits = top_bit | ~wide[W];
    end
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hi_fits,
    output logic load,
    output logic check,
    output logic step,
    output logic done,
    output logic busy
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);

    rdiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: state_d = hi_fits ? ST_DONE : ST_STEP;
            ST_STEP:  if (cnt_q == CW'(1)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHECK)
                cnt_q <= STEPS;
            else if (state_q == ST_STEP)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        load  = 1'b0;
        check = 1'b0;
        step  = 1'b0;
        done  = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin busy = 1'b0; load = start; end
            ST_CHECK: check = 1'b1;
            ST_STEP:  step = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R1: a start in IDLE moves the machine to CHECK on the next edge
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_CHECK));
    // R1: a start during the bit loop does not restart the operation
    a_r1_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && start) |=> (state_q != ST_CHECK));
    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: the step counter never runs out while steps remain
    a_r6_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (cnt_q != '0));
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           check,
    input  logic           step,
    input  logic           done,
    input  logic [2*W-1:0] dvd_mag,
    input  logic           dvd_sign,
    input  logic [W-1:0]   dvs_mag,
    input  logic           dvs_sign,
    output logic           hi_fits,
    output logic [W-1:0]   quot_mag,
    output logic           quot_sign,
    output logic [W-1:0]   rem_mag,
    output logic           rem_sign,
    output logic           ovf
);
    logic [W-1:0] acc_q, quo_q, div_q;
    logic         qs_q, rs_q, ovf_q;

    logic         top_bit;
    logic [W-1:0] part, diff;
    logic         fits;

    // In CHECK the high half is compared as is; in STEP the shifted value is.
    always_comb begin
        if (check) begin
            top_bit = 1'b0;
            part    = acc_q;
        end else begin
            top_bit = acc_q[W-1];
            part    = {acc_q[W-2:0], quo_q[W-1]};
        end
    end

    rdiv_trial_sub #(.W(W)) u_sub (
        .top_bit (top_bit),
        .part    (part),
        .divisor (div_q),
        .diff    (diff),
        .fits    (fits)
    );

    assign hi_fits = check & fits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            div_q <= '0;
            qs_q  <= 1'b0;
            rs_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else if (load) begin
            acc_q <= dvd_mag[2*W-1:W];
            quo_q <= dvd_mag[W-1:0];
            div_q <= dvs_mag;
            qs_q  <= dvd_sign ^ dvs_sign;
            rs_q  <= dvd_sign;
            ovf_q <= 1'b0;
        end else if (check) begin
            if (fits) ovf_q <= 1'b1;
        end else if (step) begin
            acc_q <= fits ? diff : part;
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign quot_mag  = quo_q;
    assign quot_sign = qs_q;
    assign rem_mag   = acc_q;
    assign rem_sign  = rs_q;
    assign ovf       = ovf_q;

    // R4: the partial remainder stays below the divisor throughout the loop
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        ((step || done) && !ovf_q) |-> (acc_q < div_q));
    // R2: an overflowed operation leaves the operand registers untouched
    a_r2_ovf_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf_q) |-> ($stable(acc_q) && $stable(quo_q)));
    // R3: ovf only rises at the end of an operation
    a_r3_ovf_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> done);
    // R7: ovf can only fall in the cycle after a load
    a_r7_ovf_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(load));
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dvd_mag,
    input  logic           dvd_sign,
    input  logic [W-1:0]   dvs_mag,
    input  logic           dvs_sign,
    output logic [W-1:0]   quot_mag,
    output logic           quot_sign,
    output logic [W-1:0]   rem_mag,
    output logic           rem_sign,
    output logic           ovf,
    output logic           done,
    output logic           busy
);
    logic load, check, step, hi_fits;

    rdiv_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .hi_fits (hi_fits),
        .load    (load),
        .check   (check),
        .step    (step),
        .done    (done),
        .busy    (busy)
    );

    rdiv_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .check     (check),
        .step      (step),
        .done      (done),
        .dvd_mag   (dvd_mag),
        .dvd_sign  (dvd_sign),
        .dvs_mag   (dvs_mag),
        .dvs_sign  (dvs_sign),
        .hi_fits   (hi_fits),
        .quot_mag  (quot_mag),
        .quot_sign (quot_sign),
        .rem_mag   (rem_mag),
        .rem_sign  (rem_sign),
        .ovf       (ovf)
    );
endmodule

// File: tb/rdiv_top_tb.sv
module rdiv_top_tb;
    localparam int W = 8;
    localparam int NV = 8;
    // each entry: {dividend[15:0], dividend sign, divisor[7:0], divisor sign}
    localparam logic [25:0] VEC [NV] = '{
        {16'h0064, 1'b0, 8'h07, 1'b0},
        {16'h1234, 1'b1, 8'h56, 1'b0},
        {16'h00FF, 1'b0, 8'h01, 1'b1},
        {16'hF000, 1'b0, 8'hFF, 1'b1},
        {16'h0500, 1'b1, 8'h05, 1'b0},
        {16'h0001, 1'b0, 8'h00, 1'b1},
        {16'hFEFF, 1'b1, 8'hFF, 1'b1},
        {16'h0000, 1'b1, 8'h09, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2*W-1:0] dvd_mag = '0;
    logic dvd_sign = 1'b0, dvs_sign = 1'b0;
    logic [W-1:0] dvs_mag = '0;
    logic [W-1:0] quot_mag, rem_mag;
    logic quot_sign, rem_sign, ovf, done, busy;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rdiv_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_mag(dvd_mag), .dvd_sign(dvd_sign),
        .dvs_mag(dvs_mag), .dvs_sign(dvs_sign),
        .quot_mag(quot_mag), .quot_sign(quot_sign),
        .rem_mag(rem_mag), .rem_sign(rem_sign),
        .ovf(ovf), .done(done), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one request at a negedge; start is taken at the next posedge
    task automatic issue(input logic [15:0] d, input logic ds,
                         input logic [7:0] v, input logic vs);
        @(negedge clk);
        dvd_mag = d; dvd_sign = ds; dvs_mag = v; dvs_sign = vs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // returns the number of posedges from acceptance until done is seen
    task automatic wait_done(output int edges);
        edges = 1;
        while (!done && edges < 100) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic run_and_check(input logic [15:0] d, input logic ds,
                                 input logic [7:0] v, input logic vs);
        int edges;
        bit ov;
        ov = (d[15:8] >= v);
        issue(d, ds, v, vs);
        wait_done(edges);
        check("R6 latency", edges, ov ? 2 : W + 2);
        check(v == 0 ? "R3 ovf zero divisor" : "R2 ovf flag", int'(ovf), int'(ov));
        if (ov) begin
            check("R2 quot holds low half", int'(quot_mag), int'(d[7:0]));
            check("R2 rem holds high half", int'(rem_mag), int'(d[15:8]));
        end else begin
            check("R4 R9 quotient", int'(quot_mag), int'(d) / int'(v));
            check("R4 R9 remainder", int'(rem_mag), int'(d) % int'(v));
        end
        check("R5 quotient sign", int'(quot_sign), int'(ds ^ vs));
        check("R5 remainder sign", int'(rem_sign), int'(ds));
        @(negedge clk);
        check("R6 done single pulse", int'(done), 0);
    endtask

    initial begin
        int edges;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 done", int'(done), 0);
        check("R8 busy", int'(busy), 0);
        check("R8 ovf", int'(ovf), 0);
        check("R8 quot", int'(quot_mag), 0);
        check("R8 rem", int'(rem_mag), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run_and_check(VEC[i][25:10], VEC[i][9], VEC[i][8:1], VEC[i][0]);

        // R7: ovf persists after done, then clears at the next accepted start
        run_and_check(16'h0900, 1'b0, 8'h03, 1'b0);
        repeat (3) @(negedge clk);
        check("R7 ovf held", int'(ovf), 1);
        issue(16'h0010, 1'b0, 8'h04, 1'b0);
        check("R7 ovf cleared on start", int'(ovf), 0);
        wait_done(edges);
        check("R7 quotient after clear", int'(quot_mag), 4);
        @(negedge clk);

        // R1: start during busy is ignored
        issue(16'h00C8, 1'b0, 8'h0A, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 busy high", int'(busy), 1);
        dvd_mag = 16'h0001; dvs_mag = 8'h00; dvd_sign = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(edges);
        check("R1 first op quotient", int'(quot_mag), 20);
        check("R1 first op ovf", int'(ovf), 0);
        check("R1 first op rem sign", int'(rem_sign), 0);
        @(negedge clk);
        check("R1 no second op", int'(busy), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule